// File: doc/BRIEF.md
# Selectable Cache Victim Picker

This block chooses which way of a k-way set-associative cache should receive the next incoming block. It keeps usage bookkeeping for every set and supports four replacement policies. A two-bit mode input selects the policy. The mode is normally held constant, but it may change at any time. The bookkeeping for all four policies runs continuously, so a change of mode takes effect on the victim output right away.

The cache controller presents a set index together with that set's valid mask. The victim way for that set appears combinationally from the registered state. Hit and fill events are reported with a strobe and a way number. They apply to the set on the index input and update the state on the next rising clock edge. The block holds no tags or data and generates no memory traffic.

Top module: `victim_picker`

## Requirements
- R1: The mode input selects the policy. Code 0 is least recently used, 1 is oldest fill, 2 is least frequently hit and 3 is pseudo-random. `victim_way` is a combinational function of the registered state of the set on `set_idx`, and it follows a change of mode within the same cycle.
- R2: When any bit of `valid_mask` is 0, `victim_way` is the lowest way index whose bit is 0. This holds in every mode.
- R3: In mode 0 the victim is the way whose most recent hit or fill lies furthest in the past. After reset the ways of every set are ordered by index: way 0 counts as most recently used and way WAYS-1 as least recently used.
- R4: In mode 1 the victim is the way whose last fill lies furthest in the past, and hits have no effect on this order. It uses the same by-index ordering after reset.
- R5: In mode 2 the victim is the way with the fewest hits since it was last filled. A tie goes to the lowest way index. All counts are zero after reset.
- R6: Each way's hit count saturates at 2^CNT_W-1 and does not wrap. A fill of a way clears that way's count to zero.
- R7: In mode 3 the victim is taken from the low log2(WAYS) bits of an 8-bit shift register. Reset loads it with 1. Every later clock shifts it left, and the new bit 0 is the XOR of the old bits 7, 5, 4 and 3.
- R8: Hit and fill updates take effect at the rising clock edge. When `hit_en` and `fill_en` are both high in the same cycle, only the fill is applied and the hit is discarded.
- R9: Every set keeps its own state. An event on one set leaves the victim choice of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Policy select (R1 codes) |
| set_idx | input | SET_W | Set for lookup and for updates |
| valid_mask | input | WAYS | Valid bit per way of the indexed set |
| hit_en | input | 1 | A hit occurred in the indexed set |
| hit_way | input | WAY_W | Way that hit |
| fill_en | input | 1 | A block was filled into the indexed set |
| fill_way | input | WAY_W | Way that was filled |
| victim_way | output | WAY_W | Chosen victim for the indexed set |

## Verification
The assertions take for granted that the way numbers on `hit_way` and `fill_way` are valid indices and that hits are reported only for ways the controller treats as live. The checks on the saturation and fill-clear counts also rely on the assertion being able to see the touched set in the cycle after the event. The stimulus drives only in-range way numbers and applies each event once per cycle. It mixes overlapping hit and fill events on purpose, because the fill-priority rule defines what happens when both strobes are high.

// File: rtl/repl_pkg.sv
package repl_pkg;
  typedef enum logic [1:0] {
    POL_LRU  = 2'd0,
    POL_FIFO = 2'd1,
    POL_LFU  = 2'd2,
    POL_RAND = 2'd3
  } policy_e;
endpackage

// File: rtl/repl_rank.sv
// Per-set recency ranking: rank 0 is newest, rank WAYS-1 is oldest.
module repl_rank #(
  parameter int WAYS = 4,
  parameter int SETS = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic [WAY_W-1:0] upd_way,
  input  logic [SET_W-1:0] look_set,
  output logic [WAY_W-1:0] oldest_way
);
  logic [WAY_W-1:0] rank_q [SETS][WAYS];
  logic [WAYS-1:0]  oldest_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          rank_q[s][w] <= WAY_W'(w);
    end else if (upd_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == upd_way)
          rank_q[upd_set][w] <= '0;
        else if (rank_q[upd_set][w] < rank_q[upd_set][upd_way])
          rank_q[upd_set][w] <= rank_q[upd_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_way  = '0;
    oldest_mask = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (rank_q[look_set][w] == WAY_W'(WAYS - 1)) begin
        oldest_way     = WAY_W'(w);
        oldest_mask[w] = 1'b1;
      end
    end
  end

  // checker state: remember the last touched entry
  logic             arm_q;
  logic [SET_W-1:0] arm_set_q;
  logic [WAY_W-1:0] arm_way_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q     <= 1'b0;
      arm_set_q <= '0;
      arm_way_q <= '0;
    end else begin
      arm_q     <= upd_en;
      arm_set_q <= upd_set;
      arm_way_q <= upd_way;
    end
  end

  // R3 / R4: a touched way becomes the newest of its set
  a_r3_touch_newest: assert property (@(posedge clk) disable iff (rst)
    arm_q |-> rank_q[arm_set_q][arm_way_q] == '0);
  // R3 / R4: ranking stays a permutation, exactly one oldest way
  a_r3_one_oldest: assert property (@(posedge clk) disable iff (rst)
    $onehot(oldest_mask));
endmodule

// File: rtl/repl_lfu.sv
// Saturating per-way hit counters with lowest-count search.
module repl_lfu #(
  parameter int WAYS  = 4,
  parameter int SETS  = 8,
  parameter int CNT_W = 3,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_en,
  input  logic             fill_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic [WAY_W-1:0] hit_way,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [SET_W-1:0] look_set,
  output logic [WAY_W-1:0] least_way
);
  logic [CNT_W-1:0] cnt_q [SETS][WAYS];
  logic [CNT_W-1:0] best_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          cnt_q[s][w] <= '0;
    end else if (fill_en) begin
      cnt_q[upd_set][fill_way] <= '0;
    end else if (hit_en && cnt_q[upd_set][hit_way] != CNT_MAX) begin
      cnt_q[upd_set][hit_way] <= cnt_q[upd_set][hit_way] + 1'b1;
    end
  end

  always_comb begin
    least_way = '0;
    best_cnt  = cnt_q[look_set][0];
    for (int w = 1; w < WAYS; w++) begin
      if (cnt_q[look_set][w] < best_cnt) begin
        best_cnt  = cnt_q[look_set][w];
        least_way = WAY_W'(w);
      end
    end
  end

  logic             sat_arm_q, clr_arm_q;
  logic [SET_W-1:0] arm_set_q;
  logic [WAY_W-1:0] arm_way_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      sat_arm_q <= 1'b0;
      clr_arm_q <= 1'b0;
      arm_set_q <= '0;
      arm_way_q <= '0;
    end else begin
      sat_arm_q <= hit_en && !fill_en && cnt_q[upd_set][hit_way] == CNT_MAX;
      clr_arm_q <= fill_en;
      arm_set_q <= upd_set;
      arm_way_q <= fill_en ? fill_way : hit_way;
    end
  end

  a_r6_sat_hold: assert property (@(posedge clk) disable iff (rst)
    sat_arm_q |-> cnt_q[arm_set_q][arm_way_q] == CNT_MAX);
  a_r6_fill_clear: assert property (@(posedge clk) disable iff (rst)
    clr_arm_q |-> cnt_q[arm_set_q][arm_way_q] == '0);
endmodule

// File: rtl/repl_lfsr.sv
// Free-running Fibonacci shift register, shifted left each clock.
module repl_lfsr #(
  parameter int LFSR_W = 8,
  parameter logic [LFSR_W-1:0] TAPS = 8'hB8,
  parameter logic [LFSR_W-1:0] SEED = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  output logic [LFSR_W-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else     state <= {state[LFSR_W-2:0], ^(state & TAPS)};
  end

  // R7: a maximal-length register never reaches the all-zero lockup
  a_r7_lfsr_live: assert property (@(posedge clk) disable iff (rst)
    state != '0);
endmodule

// File: rtl/victim_picker.sv
module victim_picker
  import repl_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int SETS   = 8,
  parameter int CNT_W  = 3,
  parameter int LFSR_W = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [SET_W-1:0] set_idx,
  input  logic [WAYS-1:0]  valid_mask,
  input  logic             hit_en,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  output logic [WAY_W-1:0] victim_way
);
  policy_e          pol;
  logic             touch_en;
  logic [WAY_W-1:0] touch_way;
  logic [WAY_W-1:0] lru_way, fifo_way, lfu_way, free_way;
  logic [LFSR_W-1:0] rnd;
  logic             any_free;

  assign pol       = policy_e'(mode);
  assign touch_en  = hit_en | fill_en;
  assign touch_way = fill_en ? fill_way : hit_way;

  repl_rank #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk(clk), .rst(rst), .upd_en(touch_en), .upd_set(set_idx),
    .upd_way(touch_way), .look_set(set_idx), .oldest_way(lru_way));

  repl_rank #(.WAYS(WAYS), .SETS(SETS)) u_fifo (
    .clk(clk), .rst(rst), .upd_en(fill_en), .upd_set(set_idx),
    .upd_way(fill_way), .look_set(set_idx), .oldest_way(fifo_way));

  repl_lfu #(.WAYS(WAYS), .SETS(SETS), .CNT_W(CNT_W)) u_lfu (
    .clk(clk), .rst(rst), .hit_en(hit_en), .fill_en(fill_en),
    .upd_set(set_idx), .hit_way(hit_way), .fill_way(fill_way),
    .look_set(set_idx), .least_way(lfu_way));

  repl_lfsr #(.LFSR_W(LFSR_W)) u_rnd (
    .clk(clk), .rst(rst), .state(rnd));

  always_comb begin
    any_free = ~&valid_mask;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid_mask[w]) free_way = WAY_W'(w);
  end

  always_comb begin
    if (any_free) victim_way = free_way;
    else begin
      unique case (pol)
        POL_LRU:  victim_way = lru_way;
        POL_FIFO: victim_way = fifo_way;
        POL_LFU:  victim_way = lfu_way;
        default:  victim_way = rnd[WAY_W-1:0];
      endcase
    end
  end

  // R2: an empty way is never passed over for a valid one
  a_r2_invalid_first: assert property (@(posedge clk) disable iff (rst)
    any_free |-> !valid_mask[victim_way]);
endmodule

// File: tb/sim_victim_picker.sv
`timescale 1ns/1ps
module sim_victim_picker;
  localparam int WAYS = 4, SETS = 8, CNT_W = 2;
  localparam int WAY_W = $clog2(WAYS), SET_W = $clog2(SETS);
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [SET_W-1:0] set_idx = '0;
  logic [WAYS-1:0] valid_mask = '1;
  logic hit_en = 1'b0, fill_en = 1'b0;
  logic [WAY_W-1:0] hit_way = '0, fill_way = '0;
  logic [WAY_W-1:0] victim_way;

  int total = 0, bad = 0;
  int m_lru [SETS][WAYS];
  int m_fifo[SETS][WAYS];
  int m_cnt [SETS][WAYS];
  logic [7:0] m_rnd;

  always #2.5 clk = ~clk;

  victim_picker #(.WAYS(WAYS), .SETS(SETS), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .set_idx(set_idx),
    .valid_mask(valid_mask), .hit_en(hit_en), .hit_way(hit_way),
    .fill_en(fill_en), .fill_way(fill_way), .victim_way(victim_way));

  // R7 reference register, built from the stated polynomial
  always @(posedge clk) begin
    if (rst) m_rnd <= 8'h01;
    else     m_rnd <= {m_rnd[6:0], m_rnd[7] ^ m_rnd[5] ^ m_rnd[4] ^ m_rnd[3]};
  end

  task automatic model_reset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_lru[s][w] = w; m_fifo[s][w] = w; m_cnt[s][w] = 0;
      end
  endtask

  task automatic bump(ref int r [SETS][WAYS], input int s, input int t);
    int old = r[s][t];
    for (int w = 0; w < WAYS; w++)
      if (w == t) r[s][w] = 0;
      else if (r[s][w] < old) r[s][w] = r[s][w] + 1;
  endtask

  function automatic int expect_way(int s, int m, logic [WAYS-1:0] mask);
    int best;
    for (int w = 0; w < WAYS; w++) if (!mask[w]) return w;
    case (m)
      0: begin for (int w = 0; w < WAYS; w++) if (m_lru[s][w] == WAYS-1) return w; end
      1: begin for (int w = 0; w < WAYS; w++) if (m_fifo[s][w] == WAYS-1) return w; end
      2: begin
        best = 0;
        for (int w = 1; w < WAYS; w++) if (m_cnt[s][w] < m_cnt[s][best]) best = w;
        return best;
      end
      default: return int'(m_rnd[WAY_W-1:0]);
    endcase
    return -1;
  endfunction

  // one clock with the given events; model updated per R8 (fill wins)
  task automatic step(bit h, bit f, int s, int hw, int fw);
    @(negedge clk);
    set_idx = SET_W'(s); hit_en = h; fill_en = f;
    hit_way = WAY_W'(hw); fill_way = WAY_W'(fw);
    @(posedge clk);
    if (f) begin
      bump(m_lru, s, fw); bump(m_fifo, s, fw); m_cnt[s][fw] = 0;
    end else if (h) begin
      bump(m_lru, s, hw);
      if (m_cnt[s][hw] < CMAX) m_cnt[s][hw] = m_cnt[s][hw] + 1;
    end
    @(negedge clk);
    hit_en = 1'b0; fill_en = 1'b0;
  endtask

  // inputs set at a falling edge, output read 1 ns later
  task automatic check(string req, int s, int m, logic [WAYS-1:0] mask);
    int exp_w;
    set_idx = SET_W'(s); mode = 2'(m); valid_mask = mask;
    #1;
    exp_w = expect_way(s, m, mask);
    total++;
    if (int'(victim_way) != exp_w) begin
      bad++;
      $display("FAIL %s set=%0d mode=%0d mask=%b actual=%0d expected=%0d",
               req, s, m, mask, victim_way, exp_w);
    end
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R3 R4 R5: reset ordering and counts, in every set
    for (int s = 0; s < SETS; s++) begin
      check("R3", s, 0, '1);
      check("R4", s, 1, '1);
      check("R5", s, 2, '1);
    end
    // R7: several successive register values
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); check("R7", 0, 3, '1);
    end
    // R2: every partially valid mask, every mode
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < (1 << WAYS) - 1; k++) check("R2", 3, m, WAYS'(k));

    // R4 vs R3: fills in order, then hits on way 0
    for (int w = 0; w < WAYS; w++) step(1'b0, 1'b1, 6, 0, w);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 6, 0, 0);
    check("R4", 6, 1, '1);
    check("R3", 6, 0, '1);
    check("R1", 6, 2, '1);

    // R6: saturation then refill, set 5
    for (int w = 0; w < WAYS; w++) step(1'b0, 1'b1, 5, 0, w);
    for (int i = 0; i < CMAX + 2; i++) step(1'b1, 1'b0, 5, 0, 0);
    for (int w = 1; w < WAYS; w++) step(1'b1, 1'b0, 5, w, 0);
    check("R6", 5, 2, '1);
    step(1'b0, 1'b1, 5, 0, 0);
    check("R6", 5, 2, '1);
    // R5: tie broken toward lowest index
    step(1'b1, 1'b0, 5, 0, 0);
    check("R5", 5, 2, '1);

    // R8 R9: mixed random events, overlapping strobes included
    for (int i = 0; i < 600; i++) begin
      int s = $urandom_range(SETS - 1);
      int r = $urandom_range(3);
      step(r[0], r[1], s, $urandom_range(WAYS - 1), $urandom_range(WAYS - 1));
      for (int c = 0; c < SETS; c++) begin
        check("R9", c, $urandom_range(2), '1);
      end
      check("R8", s, 3, '1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule